// File: doc/BRIEF.md
# TDM Bus Timing Generator

This block produces the common timing reference shared by a group of synchronous time-division multiplexed buses. It runs from one bit clock. It derives three counters from that clock: the bit position inside a slot, the slot number inside a frame, and the frame number inside a multiframe. From those counters it decodes a one-clock frame sync and a multiframe sync that stays high for a whole frame. With the defaults, a frame has 128 slots of 8 bits, so it lasts 1024 bit clocks. At the nominal bit rate this gives an 8 kHz frame rate.

A host loads a 6-bit period value. A value from 2 to 32 makes the multiframe sync repeat every that many frames. Any other value turns it off. A new value is held until the next frame boundary. It takes effect there, and the frame counter restarts at zero. Every bus that consumes these outputs sees the same slot edges, frame length and sync.

Top module: `tdm_timing_gen`

## Requirements
- R1: `bitIdx` advances by one on every clock and wraps from 7 to 0.
- R2: `slotIdx` advances by one on the clock where `bitIdx` wraps from 7, and wraps from 127 to 0, so one frame lasts 1024 clocks.
- R3: `frameSync` is high for exactly one clock per frame, the clock where `slotIdx` is 0 and `bitIdx` is 0.
- R4: When enabled, `multiSync` is high for all 1024 clocks of a frame and can change only where one frame ends and the next begins.
- R5: With an active period N between 2 and 32, `frameCount` runs 0, 1, …, N-1 and then back to 0, changing only at frame boundaries. `multiSync` is high exactly in the frames where `frameCount` is 0.
- R6: An active period of 0, 1 or 33 to 63 disables the multiframe sync: `multiSync` stays low and `frameCount` stays 0.
- R7: A value written with `periodWrEn` becomes active at the next frame boundary, and `frameCount` is 0 in the frame that follows. A later write in the same frame replaces an earlier one. A write on the last clock of a frame (slot 127, bit 7) takes effect at that same boundary.
- R8: Synchronous active-high `rst` clears the bit, slot and frame counters, leaves `multiSync` low and makes the active period "disabled".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| periodWrEn | input | 1 | Host strobe that loads a new multiframe period |
| periodWrData | input | 6 | Multiframe period in frames (2–32 valid, anything else disables) |
| bitIdx | output | 3 | Bit position inside the current slot |
| slotIdx | output | 7 | Slot number inside the current frame |
| frameSync | output | 1 | One-clock pulse at slot 0, bit 0 |
| multiSync | output | 1 | High for the whole first frame of each multiframe |
| frameCount | output | 5 | Frame number inside the multiframe |

## Verification
Two events can fall on the same clock. One is a host write that lands on the last clock of a frame. The other is the frame-boundary update, which both loads the pending period and advances or wraps the frame counter. The bench sets this up by waiting until its model is on slot 127, bit 7 with `frameCount` at 1 under a 4-frame period, and writing a new period on exactly that clock. A correct design must show `frameCount` at 0 and `multiSync` high in the very next clock. A design that misses the same-cycle write would show 2 and low instead.

// File: rtl/tdm_timing_pkg.sv
package tdm_timing_pkg;

  // Strobes issued by the control to the counter datapath each clock
  typedef struct packed {
    logic slotEnd;        // last bit of a slot
    logic frameEnd;       // last bit of the last slot of a frame
    logic restartFrames;  // at frame end, clear the frame counter
    logic frameWrap;      // frame counter is on its last value of the multiframe
  } tdm_strobe_t;

endpackage

// File: rtl/tdm_timing_dp.sv
module tdm_timing_dp
  import tdm_timing_pkg::*;
#(
  parameter int BITS_PER_SLOT   = 8,
  parameter int SLOTS_PER_FRAME = 128,
  parameter int FRAME_W         = 5,
  localparam int BIT_W          = $clog2(BITS_PER_SLOT),
  localparam int SLOT_W         = $clog2(SLOTS_PER_FRAME)
) (
  input  logic               clk,
  input  logic               rst,
  input  tdm_strobe_t        strb,
  output logic [BIT_W-1:0]   bitIdx,
  output logic [SLOT_W-1:0]  slotIdx,
  output logic [FRAME_W-1:0] frameCount
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitIdx     <= '0;
      slotIdx    <= '0;
      frameCount <= '0;
    end else begin
      bitIdx <= strb.slotEnd ? '0 : bitIdx + BIT_W'(1);
      if (strb.frameEnd) begin
        slotIdx    <= '0;
        frameCount <= (strb.restartFrames || strb.frameWrap) ? '0
                                                               : frameCount + FRAME_W'(1);
      end else if (strb.slotEnd) begin
        slotIdx <= slotIdx + SLOT_W'(1);
      end
    end
  end

endmodule

// File: rtl/tdm_timing_ctrl.sv
module tdm_timing_ctrl
  import tdm_timing_pkg::*;
#(
  parameter int BITS_PER_SLOT   = 8,
  parameter int SLOTS_PER_FRAME = 128,
  parameter int PERIOD_W        = 6,
  parameter int MIN_PERIOD      = 2,
  parameter int MAX_PERIOD      = 32,
  parameter int FRAME_W         = 5,
  localparam int BIT_W          = $clog2(BITS_PER_SLOT),
  localparam int SLOT_W         = $clog2(SLOTS_PER_FRAME)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                periodWrEn,
  input  logic [PERIOD_W-1:0] periodWrData,
  input  logic [BIT_W-1:0]    bitIdx,
  input  logic [SLOT_W-1:0]   slotIdx,
  input  logic [FRAME_W-1:0]  frameCount,
  output tdm_strobe_t         strb,
  output logic                frameSync,
  output logic                multiSync
);

  logic [PERIOD_W-1:0] activePeriod;   // 0 means disabled
  logic [PERIOD_W-1:0] pendingPeriod;
  logic                pendingValid;

  logic                takeWrite;
  logic [PERIOD_W-1:0] nextPeriod;
  logic                periodOk;
  logic                enabled;

  always_comb begin
    takeWrite  = periodWrEn || pendingValid;
    nextPeriod = periodWrEn ? periodWrData : pendingPeriod;
    periodOk   = (nextPeriod >= PERIOD_W'(MIN_PERIOD)) && (nextPeriod <= PERIOD_W'(MAX_PERIOD));
    enabled    = (activePeriod != '0);

    strb.slotEnd       = (bitIdx == BIT_W'(BITS_PER_SLOT - 1));
    strb.frameEnd      = strb.slotEnd && (slotIdx == SLOT_W'(SLOTS_PER_FRAME - 1));
    strb.restartFrames = takeWrite || !enabled;
    strb.frameWrap     = (PERIOD_W'(frameCount) == activePeriod - PERIOD_W'(1));

    frameSync = (bitIdx == '0) && (slotIdx == '0);
    multiSync = enabled && (frameCount == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activePeriod  <= '0;
      pendingPeriod <= '0;
      pendingValid  <= 1'b0;
    end else if (strb.frameEnd) begin
      if (takeWrite) begin
        activePeriod <= periodOk ? nextPeriod : '0;
      end
      pendingValid <= 1'b0;
    end else if (periodWrEn) begin
      pendingPeriod <= periodWrData;
      pendingValid  <= 1'b1;
    end
  end

endmodule

// File: rtl/tdm_timing_gen.sv
module tdm_timing_gen
  import tdm_timing_pkg::*;
#(
  parameter int BITS_PER_SLOT   = 8,
  parameter int SLOTS_PER_FRAME = 128,
  parameter int PERIOD_W        = 6,
  parameter int MIN_PERIOD      = 2,
  parameter int MAX_PERIOD      = 32,
  localparam int BIT_W          = $clog2(BITS_PER_SLOT),
  localparam int SLOT_W         = $clog2(SLOTS_PER_FRAME),
  localparam int FRAME_W        = $clog2(MAX_PERIOD)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                periodWrEn,
  input  logic [PERIOD_W-1:0] periodWrData,
  output logic [BIT_W-1:0]    bitIdx,
  output logic [SLOT_W-1:0]   slotIdx,
  output logic                frameSync,
  output logic                multiSync,
  output logic [FRAME_W-1:0]  frameCount
);

  tdm_strobe_t strb;

  tdm_timing_ctrl #(
    .BITS_PER_SLOT(BITS_PER_SLOT), .SLOTS_PER_FRAME(SLOTS_PER_FRAME),
    .PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD),
    .FRAME_W(FRAME_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .periodWrEn(periodWrEn), .periodWrData(periodWrData),
    .bitIdx(bitIdx), .slotIdx(slotIdx), .frameCount(frameCount),
    .strb(strb), .frameSync(frameSync), .multiSync(multiSync)
  );

  tdm_timing_dp #(
    .BITS_PER_SLOT(BITS_PER_SLOT), .SLOTS_PER_FRAME(SLOTS_PER_FRAME), .FRAME_W(FRAME_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .bitIdx(bitIdx), .slotIdx(slotIdx), .frameCount(frameCount)
  );

endmodule

// File: rtl/tdm_timing_checker.sv
module tdm_timing_checker #(
  parameter int BITS_PER_SLOT   = 8,
  parameter int SLOTS_PER_FRAME = 128,
  parameter int FRAME_W         = 5,
  localparam int BIT_W          = $clog2(BITS_PER_SLOT),
  localparam int SLOT_W         = $clog2(SLOTS_PER_FRAME)
) (
  input logic               clk,
  input logic               rst,
  input logic [BIT_W-1:0]   bitIdx,
  input logic [SLOT_W-1:0]  slotIdx,
  input logic               frameSync,
  input logic               multiSync,
  input logic [FRAME_W-1:0] frameCount
);

  logic lastBit, lastPos;
  logic rstQ = 1'b0;

  assign lastBit = (bitIdx == BIT_W'(BITS_PER_SLOT - 1));
  assign lastPos = lastBit && (slotIdx == SLOT_W'(SLOTS_PER_FRAME - 1));

  assert_bit_step_R1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> bitIdx == (($past(bitIdx) == BIT_W'(BITS_PER_SLOT - 1)) ? BIT_W'(0)
                                                                     : BIT_W'($past(bitIdx) + 1)));

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst && !lastBit) |=> $stable(slotIdx));

  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst && lastPos) |=> slotIdx == '0);

  assert_fsync_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    frameSync |=> !frameSync);

  assert_fsync_place_R3: assert property (@(posedge clk) disable iff (rst)
    frameSync |-> (slotIdx == '0 && bitIdx == '0));

  assert_msync_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst && !lastPos) |=> $stable(multiSync));

  assert_fcount_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && !lastPos) |=> $stable(frameCount));

  assert_msync_zero_R5: assert property (@(posedge clk) disable iff (rst)
    multiSync |-> frameCount == '0);

  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rstQ) begin
      assert_reset_state_R8: assert (bitIdx == '0 && slotIdx == '0 &&
                                     frameCount == '0 && !multiSync);
    end
  end

endmodule

bind tdm_timing_gen tdm_timing_checker #(
  .BITS_PER_SLOT(BITS_PER_SLOT), .SLOTS_PER_FRAME(SLOTS_PER_FRAME), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst(rst), .bitIdx(bitIdx), .slotIdx(slotIdx),
  .frameSync(frameSync), .multiSync(multiSync), .frameCount(frameCount)
);

// File: tb/tdm_timing_gen_bench.sv
module tdm_timing_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BITS   = 8;
  localparam int SLOTS  = 128;
  localparam int FRAME  = BITS * SLOTS;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       periodWrEn = 1'b0;
  logic [5:0] periodWrData = '0;
  logic [2:0] bitIdx;
  logic [6:0] slotIdx;
  logic       frameSync;
  logic       multiSync;
  logic [4:0] frameCount;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  // bench model state
  int mBit = 0, mSlot = 0, mFc = 0, mActive = 0, mPendVal = 0;
  bit mPend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_timing_gen u_tdm_timing_gen (
    .clk(clk), .rst(rst), .periodWrEn(periodWrEn), .periodWrData(periodWrData),
    .bitIdx(bitIdx), .slotIdx(slotIdx), .frameSync(frameSync),
    .multiSync(multiSync), .frameCount(frameCount)
  );

  function automatic bit periodValid(int n);
    return (n >= 2) && (n <= 32);
  endfunction

  function automatic bit expMulti();
    return periodValid(mActive) && (mFc == 0);
  endfunction

  function automatic bit atLast();
    return (mBit == BITS - 1) && (mSlot == SLOTS - 1);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d (slot %0d bit %0d)",
               req, what, act, exp, mSlot, mBit);
    end
  endtask

  task automatic modelEdge(bit r, bit we, int wd);
    bit effPend;
    int effVal;
    bit lastB;
    if (r) begin
      mBit = 0; mSlot = 0; mFc = 0; mActive = 0; mPend = 0; mPendVal = 0;
      return;
    end
    lastB   = (mBit == BITS - 1);
    effPend = we || mPend;
    effVal  = we ? wd : mPendVal;
    if (atLast()) begin
      if (effPend) begin
        mActive = periodValid(effVal) ? effVal : 0;
        mFc = 0;
      end else if (!periodValid(mActive)) begin
        mFc = 0;
      end else begin
        mFc = (mFc == mActive - 1) ? 0 : mFc + 1;
      end
      mPend = 0;
    end else if (we) begin
      mPend = 1; mPendVal = wd;
    end
    mBit = lastB ? 0 : mBit + 1;
    if (lastB) mSlot = (mSlot == SLOTS - 1) ? 0 : mSlot + 1;
  endtask

  task automatic compareAll();
    bit en;
    en = periodValid(mActive);
    check("R1", "bitIdx", int'(bitIdx), mBit);
    check("R2", "slotIdx", int'(slotIdx), mSlot);
    check("R3", "frameSync", int'(frameSync), int'(mBit == 0 && mSlot == 0));
    check(en ? "R4" : "R6", "multiSync", int'(multiSync), int'(expMulti()));
    check(en ? "R5" : "R6", "frameCount", int'(frameCount), mFc);
  endtask

  // one clock: drive inputs, advance model, sample after the edge
  task automatic step(bit r, bit we, int wd);
    rst = r; periodWrEn = we; periodWrData = 6'(wd);
    modelEdge(r, we, wd);
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0);
  endtask

  initial begin
    int unsigned seedJunk;
    seedJunk = $urandom(32'h7d3a_1c05);
    @(negedge clk);

    // R8: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0);
    check("R8", "reset bitIdx", int'(bitIdx), 0);
    check("R8", "reset slotIdx", int'(slotIdx), 0);
    check("R8", "reset frameCount", int'(frameCount), 0);
    check("R8", "reset multiSync", int'(multiSync), 0);

    // R6: disabled after reset, one frame
    runCycles(FRAME);

    // R5: period 2 written mid-frame
    runCycles(37);
    step(1'b0, 1'b1, 2);
    check("R7", "held until boundary", int'(multiSync), 0);
    runCycles(5 * FRAME);

    // R7: later write in same frame supersedes earlier one
    runCycles(100);
    step(1'b0, 1'b1, 3);
    runCycles(50);
    step(1'b0, 1'b1, 4);
    while (!atLast()) step(1'b0, 1'b0, 0);
    step(1'b0, 1'b0, 0);
    check("R7", "restart frameCount", int'(frameCount), 0);
    check("R7", "multiSync after load", int'(multiSync), 1);
    runCycles(3 * FRAME);
    check("R5", "period 4 count", int'(frameCount), 3);

    // R7: write on the very last clock of a frame, frameCount at 1
    while (!(atLast() && mFc == 1)) step(1'b0, 1'b0, 0);
    step(1'b0, 1'b1, 5);
    check("R7", "same-cycle write frameCount", int'(frameCount), 0);
    check("R7", "same-cycle write multiSync", int'(multiSync), 1);
    runCycles(6 * FRAME);

    // R6: disabling values
    step(1'b0, 1'b1, 0);
    runCycles(2 * FRAME);
    check("R6", "period 0 multiSync", int'(multiSync), 0);
    step(1'b0, 1'b1, 1);
    runCycles(2 * FRAME);
    check("R6", "period 1 frameCount", int'(frameCount), 0);
    step(1'b0, 1'b1, 33);
    runCycles(2 * FRAME);
    check("R6", "period 33 multiSync", int'(multiSync), 0);
    step(1'b0, 1'b1, 63);
    runCycles(FRAME + 10);
    check("R6", "period 63 frameCount", int'(frameCount), 0);

    // R5: longest period
    step(1'b0, 1'b1, 32);
    runCycles(33 * FRAME);

    // random writes across 30 frames
    for (int i = 0; i < 30 * FRAME; i++) begin
      if ($urandom_range(0, 1499) == 0)
        step(1'b0, 1'b1, (($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 63))
                                                       : int'($urandom_range(2, 6))));
      else
        step(1'b0, 1'b0, 0);
    end

    // R8: reset in the middle of a frame
    step(1'b0, 1'b1, 3);
    runCycles(300);
    step(1'b1, 1'b0, 0);
    step(1'b1, 1'b0, 0);
    check("R8", "mid reset slotIdx", int'(slotIdx), 0);
    check("R8", "mid reset multiSync", int'(multiSync), 0);
    runCycles(2 * FRAME);
    check("R8", "period cleared by reset", int'(multiSync), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule